// File: doc/BRIEF.md
# Cascadable Counter Group with Coherent Snapshot

The block holds a group of four 16-bit counters that share one clock and one count-enable input. Each counter either counts on that enable (up or down, between zero and its own compare value) or is cascaded from another counter in the group. A cascaded counter steps exactly when its source produces a compare event. The step direction is the direction the source was moving at that event. Chaining counters this way gives synchronous counters of 32, 48 or 64 bits. Carries and borrows pass through every stage on one clock edge.

A single read port serves two kinds of read. A live read returns one counter's value. In the same cycle it copies every counter into its own hold register. A hold read returns one of those stored copies and leaves the copies unchanged. To read a wide value, software does a live read of one stage and then hold reads of the other stages. All parts of the value then come from the same clock edge.

Top module: `cascade_counter_group`

## Requirements
- R1: After reset every counter, every hold register and the read data output are zero.
- R2: Mode code 3'b001 counts up by one on each cycle with the count enable high. A counter equal to its compare value reloads to zero on its next step, and that step is a compare event. Mode 3'b000, and any code not named in R2, R3 or R4, holds the value.
- R3: Mode code 3'b010 counts down by one on each enabled cycle. A counter at zero reloads its compare value on its next step, and that step is a compare event.
- R4: Mode code 3'b111 makes the counter step only on compare events of the counter named by its 2-bit source field. The step is an increment when the source was counting up, and it lands on the same clock edge as the source's event.
- R5: In mode 3'b111, a compare event of a source that is counting down decrements the cascaded counter. A cascaded counter passes its own events and its direction on to the counters that select it.
- R6: Four counters chained with compare value 16'hFFFF act as one 64-bit counter. A single step moves the chain from all ones to zero, or from zero to all ones, on one edge.
- R7: A counter in mode 3'b111 whose source field names itself ignores the selection and holds its value.
- R8: A read strobe with the hold select low is a live read. It returns, one cycle later on the read data output, the addressed counter's value at the strobe edge, and on that same edge it loads every hold register with its counter's value.
- R9: A read strobe with the hold select high returns the addressed hold register one cycle later and changes no hold register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_en_i | input | 1 | Shared count enable for non-cascaded counters |
| mode_i | input | 12 | Mode field per counter, 3 bits each, counter k at [3k+2:3k] |
| src_i | input | 8 | Cascade source index per counter, 2 bits each, counter k at [2k+1:2k] |
| cmp_i | input | 64 | Compare value per counter, 16 bits each, counter k at [16k+15:16k] |
| rd_en_i | input | 1 | Read strobe |
| rd_hold_i | input | 1 | 0: live read with snapshot, 1: hold register read |
| rd_addr_i | input | 2 | Counter index to read |
| rd_data_o | output | 16 | Registered read data |

## Verification
A wrong event or direction path shows at the ports as a wrong value in a cascaded stage. The wrong value is visible at the first live or hold read after the source's compare edge, one cycle after the strobe. The carry tests place the source stage exactly at its limit, so a stage that lags by one edge is caught immediately and is not hidden by later counting. A snapshot fault shows as a hold read that disagrees with a live read taken at the same edge. A snapshot fault also shows as a hold value that moves between two hold reads with no live read between them.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
  typedef enum logic [2:0] {
    MODE_OFF  = 3'b000,
    MODE_UP   = 3'b001,
    MODE_DOWN = 3'b010,
    MODE_CASC = 3'b111
  } cc_mode_e;
endpackage

// File: rtl/cc_event_net.sv
`timescale 1ns/1ps
// Resolves per-counter step and direction in N_CNT passes; a chain of depth
// k settles at pass k, so cascade cycles without a root never step.
module cc_event_net
  import cc_pkg::*;
#(
  parameter int N_CNT = 4,
  parameter int SEL_W = 2
) (
  input  logic [N_CNT-1:0][2:0]       mode_i,
  input  logic [N_CNT-1:0][SEL_W-1:0] src_i,
  input  logic                        count_en_i,
  input  logic [N_CNT-1:0]            at_lim_i,
  output logic [N_CNT-1:0]            step_o,
  output logic [N_CNT-1:0]            down_o
);
  logic [N_CNT-1:0] casc_ok;

  for (genvar i = 0; i < N_CNT; i++) begin : g_ok
    localparam logic [SEL_W-1:0] SelfIdx = SEL_W'(i);
    assign casc_ok[i] = (mode_i[i] == MODE_CASC) && (src_i[i] != SelfIdx)
                        && (int'(src_i[i]) < N_CNT);
  end

  for (genvar p = 0; p < N_CNT; p++) begin : g_pass
    logic [N_CNT-1:0] step, down, evt;
    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
      if (p == 0) begin : g_root
        assign step[i] = count_en_i &&
                         ((mode_i[i] == MODE_UP) || (mode_i[i] == MODE_DOWN));
        assign down[i] = (mode_i[i] == MODE_DOWN);
      end else begin : g_chain
        assign step[i] = casc_ok[i] ? g_pass[p-1].evt[src_i[i]]  : g_pass[0].step[i];
        assign down[i] = casc_ok[i] ? g_pass[p-1].down[src_i[i]] : g_pass[0].down[i];
      end
      assign evt[i] = step[i] & at_lim_i[i];
    end
  end

  assign step_o = g_pass[N_CNT-1].step;
  assign down_o = g_pass[N_CNT-1].down;
endmodule

// File: rtl/cc_counter.sv
`timescale 1ns/1ps
module cc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_lim_o
);
  logic [CNT_W-1:0] cnt_q;

  assign at_lim_o = down_i ? (cnt_q == '0) : (cnt_q == cmp_i);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (step_i) begin
      if (at_lim_o)    cnt_q <= down_i ? cmp_i : '0;
      else if (down_i) cnt_q <= cnt_q - 1'b1;
      else             cnt_q <= cnt_q + 1'b1;
    end
  end

  p_wrap_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !down_i && at_lim_o |=> cnt_q == '0);
  p_reload_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && down_i && at_lim_o |=> cnt_q == $past(cmp_i));
  p_step_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !down_i && !at_lim_o |=> cnt_q == $past(cnt_q) + 1'b1);
  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/cc_snapshot.sv
`timescale 1ns/1ps
module cc_snapshot #(
  parameter int N_CNT = 4,
  parameter int CNT_W = 16,
  parameter int SEL_W = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_en_i,
  input  logic                        rd_hold_i,
  input  logic [SEL_W-1:0]            rd_addr_i,
  input  logic [N_CNT-1:0][CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0]            rd_data_o
);
  logic [N_CNT-1:0][CNT_W-1:0] hold_q;
  logic                        capture, addr_ok;

  assign capture = rd_en_i && !rd_hold_i;
  assign addr_ok = int'(rd_addr_i) < N_CNT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= '0;
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      if (capture) hold_q <= cnt_i;
      if (!addr_ok)       rd_data_o <= '0;
      else if (rd_hold_i) rd_data_o <= hold_q[rd_addr_i];
      else                rd_data_o <= cnt_i[rd_addr_i];
    end
  end

  for (genvar k = 0; k < N_CNT; k++) begin : g_chk
    p_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      capture |=> hold_q[k] == $past(cnt_i[k]));
  end
  p_hold_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture |=> $stable(hold_q));
  p_live_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture && addr_ok |=> rd_data_o == $past(cnt_i[rd_addr_i]));
endmodule

// File: rtl/cascade_counter_group.sv
`timescale 1ns/1ps
module cascade_counter_group
  import cc_pkg::*;
#(
  parameter int N_CNT = 4,
  parameter int CNT_W = 16,
  localparam int SEL_W = (N_CNT > 1) ? $clog2(N_CNT) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     count_en_i,
  input  logic [N_CNT*3-1:0]       mode_i,
  input  logic [N_CNT*SEL_W-1:0]   src_i,
  input  logic [N_CNT*CNT_W-1:0]   cmp_i,
  input  logic                     rd_en_i,
  input  logic                     rd_hold_i,
  input  logic [SEL_W-1:0]         rd_addr_i,
  output logic [CNT_W-1:0]         rd_data_o
);
  logic [N_CNT-1:0][2:0]       mode_v;
  logic [N_CNT-1:0][SEL_W-1:0] src_v;
  logic [N_CNT-1:0][CNT_W-1:0] cmp_v, cnt_v;
  logic [N_CNT-1:0]            step_w, down_w, at_lim_w;

  assign mode_v = mode_i;
  assign src_v  = src_i;
  assign cmp_v  = cmp_i;

  cc_event_net #(.N_CNT(N_CNT), .SEL_W(SEL_W)) u_net (
    .mode_i     (mode_v),
    .src_i      (src_v),
    .count_en_i (count_en_i),
    .at_lim_i   (at_lim_w),
    .step_o     (step_w),
    .down_o     (down_w)
  );

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    cc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (step_w[i]),
      .down_i   (down_w[i]),
      .cmp_i    (cmp_v[i]),
      .cnt_o    (cnt_v[i]),
      .at_lim_o (at_lim_w[i])
    );

    localparam logic [SEL_W-1:0] SelfIdx = SEL_W'(i);
    logic self_sel, casc_src;
    assign self_sel = (mode_v[i] == MODE_CASC) && (src_v[i] == SelfIdx);
    assign casc_src = (mode_v[i] == MODE_CASC) && (src_v[i] != SelfIdx)
                      && (int'(src_v[i]) < N_CNT);

    p_self_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      self_sel |=> $stable(cnt_v[i]));
    p_casc_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      casc_src && step_w[src_v[i]] && at_lim_w[src_v[i]] && !down_w[src_v[i]]
      && !at_lim_w[i] |=> cnt_v[i] == $past(cnt_v[i]) + 1'b1);
    p_casc_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      casc_src && step_w[src_v[i]] && at_lim_w[src_v[i]] && down_w[src_v[i]]
      && !at_lim_w[i] |=> cnt_v[i] == $past(cnt_v[i]) - 1'b1);
  end

  cc_snapshot #(.N_CNT(N_CNT), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_snap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_hold_i (rd_hold_i),
    .rd_addr_i (rd_addr_i),
    .cnt_i     (cnt_v),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: tb/cascade_counter_group_tb_top.sv
`timescale 1ns/1ps
module cascade_counter_group_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        count_en = 1'b0;
  logic [11:0] mode = '0;
  logic [7:0]  src = '0;
  logic [63:0] cmp = '0;
  logic        rd_en = 1'b0, rd_hold = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cascade_counter_group dut_i (
    .clk_i(clk), .rst_ni(rst_n), .count_en_i(count_en), .mode_i(mode),
    .src_i(src), .cmp_i(cmp), .rd_en_i(rd_en), .rd_hold_i(rd_hold),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; count_en = 1'b0; mode = '0; src = '0; cmp = '0;
    rd_en = 1'b0; rd_hold = 1'b0; rd_addr = '0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic cfg(int i, logic [2:0] m, logic [1:0] s, logic [15:0] c);
    mode[i*3 +: 3]  = m;
    src[i*2 +: 2]   = s;
    cmp[i*16 +: 16] = c;
  endtask

  task automatic tick(int n);
    @(negedge clk) count_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk) count_en = 1'b0;
  endtask

  task automatic rd(bit hold, int a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_hold = hold; rd_addr = 2'(a);
    @(posedge clk);
    #1 d = rd_data;
    @(negedge clk) rd_en = 1'b0;
  endtask

  task automatic t_reset_r1();
    logic [15:0] d;
    do_reset();
    #1 chk("R1 rd_data", rd_data, 16'h0);
    rd(1'b1, 3, d); chk("R1 hold3", d, 16'h0);
    rd(1'b0, 2, d); chk("R1 cnt2", d, 16'h0);
  endtask

  task automatic t_up_r2();
    logic [15:0] d;
    do_reset();
    cfg(0, 3'b001, 2'd0, 16'd4);
    cfg(2, 3'b011, 2'd0, 16'd9);
    tick(3);
    rd(1'b0, 0, d); chk("R2 up 3", d, 16'd3);
    tick(2);
    rd(1'b0, 0, d); chk("R2 wrap", d, 16'd0);
    rd(1'b0, 1, d); chk("R2 off holds", d, 16'd0);
    rd(1'b1, 2, d); chk("R2 other code holds", d, 16'd0);
  endtask

  task automatic t_down_r3();
    logic [15:0] d;
    do_reset();
    cfg(0, 3'b010, 2'd0, 16'd5);
    tick(1);
    rd(1'b0, 0, d); chk("R3 reload", d, 16'd5);
    tick(2);
    rd(1'b0, 0, d); chk("R3 down", d, 16'd3);
  endtask

  task automatic t_casc_up_r4();
    logic [15:0] d;
    do_reset();
    cfg(0, 3'b001, 2'd0, 16'd2);
    cfg(1, 3'b111, 2'd0, 16'd9);
    tick(3);
    rd(1'b0, 0, d); chk("R4 src wrapped", d, 16'd0);
    rd(1'b1, 1, d); chk("R4 same edge inc", d, 16'd1);
    tick(4);
    rd(1'b0, 1, d); chk("R4 second inc", d, 16'd2);
  endtask

  task automatic t_casc_down_r5();
    logic [15:0] d;
    do_reset();
    cfg(0, 3'b010, 2'd0, 16'd2);
    cfg(1, 3'b111, 2'd0, 16'd3);
    tick(1);
    rd(1'b0, 0, d); chk("R5 src reload", d, 16'd2);
    rd(1'b1, 1, d); chk("R5 casc borrow reload", d, 16'd3);
    tick(3);
    rd(1'b0, 1, d); chk("R5 dec", d, 16'd2);
  endtask

  task automatic t_chain64_r6();
    logic [15:0] d;
    do_reset();
    cfg(0, 3'b010, 2'd0, 16'hFFFF);
    cfg(1, 3'b111, 2'd0, 16'hFFFF);
    cfg(2, 3'b111, 2'd1, 16'hFFFF);
    cfg(3, 3'b111, 2'd2, 16'hFFFF);
    tick(1);
    rd(1'b0, 3, d); chk("R6 borrow s3", d, 16'hFFFF);
    for (int k = 0; k < 3; k++) begin
      rd(1'b1, k, d); chk("R6 borrow low", d, 16'hFFFF);
    end
    @(negedge clk) cfg(0, 3'b001, 2'd0, 16'hFFFF);
    tick(1);
    rd(1'b0, 0, d); chk("R6 carry s0", d, 16'h0);
    for (int k = 1; k < 4; k++) begin
      rd(1'b1, k, d); chk("R6 carry high", d, 16'h0);
    end
    tick(1);
    rd(1'b0, 0, d); chk("R6 step s0", d, 16'h1);
    rd(1'b1, 3, d); chk("R6 s3 stays", d, 16'h0);
  endtask

  task automatic t_self_r7();
    logic [15:0] d;
    do_reset();
    cfg(0, 3'b001, 2'd0, 16'd1);
    cfg(1, 3'b111, 2'd1, 16'd9);
    tick(4);
    rd(1'b0, 1, d); chk("R7 self select holds", d, 16'd0);
  endtask

  task automatic t_snap_r8_r9();
    logic [15:0] d;
    do_reset();
    cfg(0, 3'b001, 2'd0, 16'd2);
    cfg(1, 3'b111, 2'd0, 16'd9);
    tick(5);
    rd(1'b0, 1, d); chk("R8 live read", d, 16'd1);
    tick(2);
    rd(1'b1, 0, d); chk("R8 hold keeps snapshot", d, 16'd2);
    rd(1'b1, 1, d); chk("R8 hold casc", d, 16'd1);
    rd(1'b1, 0, d); chk("R9 hold read no capture", d, 16'd2);
    rd(1'b0, 0, d); chk("R8 live after", d, 16'd1);
    rd(1'b1, 1, d); chk("R8 new snapshot", d, 16'd2);
  endtask

  initial begin
    t_reset_r1();
    t_up_r2();
    t_down_r3();
    t_casc_up_r4();
    t_casc_down_r5();
    t_chain64_r6();
    t_self_r7();
    t_snap_r8_r9();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule